// File: doc/BRIEF.md
# Runtime-Configurable GPIO Pin Multiplexer

This block is a register-programmed crossbar between a motion-control core and the physical pin pads. The core presents split buses: output data, output enable and input data. Each physical pin holds an 8-bit selector that picks which core signal the pin carries. The pad side gets separate out, oe and in vectors, and the tristate is built only at the chip top. Software can move any core function to any muxed pin while the design runs. After reset every pin carries the core signal of the same number.

Pins are grouped in ports of `PORT_W` pads. The top `LEDS_PER_PORT` positions of each port bypass the crossbar and drive LED inputs. Every muxed pin also has three control bits:
- a direction bit;
- an output-invert bit;
- an open-drain bit.

Software reaches all of these registers through a simple 32-bit word-addressed slave with byte enables. The same slave returns a raw snapshot of every pad input.

Top module: `gpio_pin_xbar`

## Requirements
- R1: After reset, the selector of muxed pin m holds m, so pin m carries core signal m. All direction, invert and open-drain bits reset to 0, and rdata resets to 0.
- R2: Selector word 0x1120+w holds the selectors of muxed pins 4w to 4w+3. The selector of pin 4w+b sits in bits 8b+7 down to 8b. Control words 0x1100+w (direction), 0x1108+w (invert) and 0x1110+w (open-drain) hold pin 32w+j in bit j. A read returns the stored values, with unused bytes and bits reading 0.
- R3: A write changes only the bytes whose byte-enable bit is set. be[b] covers wdata bits 8b+7 down to 8b.
- R4: With a selector s below NUM_CORE, the pin is enabled when its direction bit or core_oe[s] is 1. An enabled pin outputs core_out[s]. A disabled pin has pad_oe 0 and pad_out 0.
- R5: A selector value of NUM_CORE or above forces pad_oe 0 and pad_out 0, whatever the direction bit holds.
- R6: When its invert bit is 1, an enabled pin drives the complement of the selected core output.
- R7: When its open-drain bit is 1, the pad_out of that pin is always 0. Its pad_oe is 1 only when the pin is enabled and the driven value, after invert, is 0.
- R8: core_in[k] is the OR of the pad inputs of all muxed pins whose selector equals k. It is 0 when no pin selects k.
- R9: Reading word 0x1118+w returns pad inputs 32w to 32w+31 unmodified, LED pads included.
- R10: Pad position p of a port, with p at or above PORT_W-LEDS_PER_PORT, drives its LED input with pad_oe 1. No selector affects it. LED index = port*LEDS_PER_PORT + (p-(PORT_W-LEDS_PER_PORT)).
- R11: A register write takes effect on the pads after the clock edge that accepts it, and not before. With no write and stable core and LED inputs, pad outputs hold steady.
- R12: rdata changes only on the clock edge that samples rd_en high. It then shows the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Word address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables for writes |
| rdata | output | 32 | Registered read data |
| core_out | input | NUM_CORE | Core output data bus |
| core_oe | input | NUM_CORE | Core output-enable bus |
| core_in | output | NUM_CORE | Pad inputs routed back to the core |
| led_i | input | NUM_PORTS*LEDS_PER_PORT | LED drive values |
| pad_in | input | NUM_PORTS*PORT_W | Pad input levels |
| pad_out | output | NUM_PORTS*PORT_W | Pad output data |
| pad_oe | output | NUM_PORTS*PORT_W | Pad output enables |

## Verification
The bench builds the block with two ports of 37 pads and 40 core signals. This gives 70 muxed pins but only 40 core signals, so the reset mapping already leaves pins 40 to 69 with out-of-range selectors. The value 40 itself is exercised as the exact boundary.

With two ports, the second port's pad numbering is offset from its muxed-pin numbering. The LED bypass appears at two places in the pad vector. The selector bank has a partially used last word. The raw input vector spans three read words.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int ADDR_W   = 16;
    localparam int DIR_BASE = 'h1100;
    localparam int INV_BASE = 'h1108;
    localparam int OD_BASE  = 'h1110;
    localparam int RAW_BASE = 'h1118;
    localparam int SEL_BASE = 'h1120;
    localparam int SEL_W    = 8;
endpackage

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int NUM_MUX  = 35,
    parameter int NUM_PADS = 37
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [31:0]                   wdata,
    input  logic [3:0]                    be,
    input  logic [NUM_PADS-1:0]           raw_in,
    output logic [31:0]                   rdata,
    output logic [NUM_MUX-1:0][SEL_W-1:0] sel,
    output logic [NUM_MUX-1:0]            dir,
    output logic [NUM_MUX-1:0]            inv,
    output logic [NUM_MUX-1:0]            od
);
    typedef struct packed {
        logic [NUM_MUX-1:0][SEL_W-1:0] sel;
        logic [NUM_MUX-1:0]            dir;
        logic [NUM_MUX-1:0]            inv;
        logic [NUM_MUX-1:0]            od;
        logic [31:0]                   rdata;
    } regs_t;

    regs_t r_d, r_q;

    function automatic regs_t reset_val();
        regs_t v;
        v = '0;
        for (int i = 0; i < NUM_MUX; i++) v.sel[i] = SEL_W'(i);
        return v;
    endfunction

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int word);
        return a == ADDR_W'(word);
    endfunction

    always_comb begin
        logic [31:0] rv;
        r_d = r_q;
        rv  = '0;
        for (int i = 0; i < NUM_MUX; i++) begin
            if (wr_en && hit(addr, SEL_BASE + i / 4) && be[i % 4])
                r_d.sel[i] = wdata[8 * (i % 4) +: 8];
            if (wr_en && hit(addr, DIR_BASE + i / 32) && be[(i % 32) / 8])
                r_d.dir[i] = wdata[i % 32];
            if (wr_en && hit(addr, INV_BASE + i / 32) && be[(i % 32) / 8])
                r_d.inv[i] = wdata[i % 32];
            if (wr_en && hit(addr, OD_BASE + i / 32) && be[(i % 32) / 8])
                r_d.od[i] = wdata[i % 32];
            if (hit(addr, SEL_BASE + i / 4)) rv[8 * (i % 4) +: 8] = r_q.sel[i];
            if (hit(addr, DIR_BASE + i / 32)) rv[i % 32] = r_q.dir[i];
            if (hit(addr, INV_BASE + i / 32)) rv[i % 32] = r_q.inv[i];
            if (hit(addr, OD_BASE + i / 32)) rv[i % 32] = r_q.od[i];
        end
        for (int p = 0; p < NUM_PADS; p++) begin
            if (hit(addr, RAW_BASE + p / 32)) rv[p % 32] = raw_in[p];
        end
        if (rd_en) r_d.rdata = rv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= reset_val();
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
    assign sel   = r_q.sel;
    assign dir   = r_q.dir;
    assign inv   = r_q.inv;
    assign od    = r_q.od;
endmodule

// File: rtl/gpx_route.sv
module gpx_route
    import gpx_pkg::*;
#(
    parameter int NUM_MUX  = 35,
    parameter int NUM_CORE = 35
) (
    input  logic [NUM_MUX-1:0][SEL_W-1:0] sel,
    input  logic [NUM_CORE-1:0]           core_out,
    input  logic [NUM_CORE-1:0]           core_oe,
    input  logic [NUM_MUX-1:0]            pin_in,
    output logic [NUM_MUX-1:0]            pin_valid,
    output logic [NUM_MUX-1:0]            pin_d,
    output logic [NUM_MUX-1:0]            pin_coe,
    output logic [NUM_CORE-1:0]           core_in
);
    localparam int SPAN = 1 << SEL_W;

    logic [SPAN-1:0] out_x, oe_x;
    assign out_x = SPAN'(core_out);
    assign oe_x  = SPAN'(core_oe);

    for (genvar m = 0; m < NUM_MUX; m++) begin : g_pin
        assign pin_valid[m] = int'(sel[m]) < NUM_CORE;
        assign pin_d[m]     = pin_valid[m] & out_x[sel[m]];
        assign pin_coe[m]   = pin_valid[m] & oe_x[sel[m]];
    end

    always_comb begin
        core_in = '0;
        for (int k = 0; k < NUM_CORE; k++) begin
            for (int m = 0; m < NUM_MUX; m++) begin
                if (sel[m] == SEL_W'(k)) core_in[k] = core_in[k] | pin_in[m];
            end
        end
    end
endmodule

// File: rtl/gpx_pad.sv
module gpx_pad (
    input  logic valid,
    input  logic d,
    input  logic coe,
    input  logic dir,
    input  logic inv,
    input  logic od,
    output logic pout,
    output logic poe
);
    logic en, dv;
    always_comb begin
        en = valid & (dir | coe);
        dv = d ^ inv;
        if (od) begin
            poe  = en & ~dv;
            pout = 1'b0;
        end else begin
            poe  = en;
            pout = en & dv;
        end
    end
endmodule

// File: rtl/gpio_pin_xbar.sv
module gpio_pin_xbar
    import gpx_pkg::*;
#(
    parameter int NUM_PORTS     = 1,
    parameter int PORT_W        = 37,
    parameter int LEDS_PER_PORT = 2,
    parameter int NUM_CORE      = 35
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic                               rd_en,
    input  logic [15:0]                        addr,
    input  logic [31:0]                        wdata,
    input  logic [3:0]                         be,
    output logic [31:0]                        rdata,
    input  logic [NUM_CORE-1:0]                core_out,
    input  logic [NUM_CORE-1:0]                core_oe,
    output logic [NUM_CORE-1:0]                core_in,
    input  logic [NUM_PORTS*LEDS_PER_PORT-1:0] led_i,
    input  logic [NUM_PORTS*PORT_W-1:0]        pad_in,
    output logic [NUM_PORTS*PORT_W-1:0]        pad_out,
    output logic [NUM_PORTS*PORT_W-1:0]        pad_oe
);
    localparam int MUX_PER_PORT = PORT_W - LEDS_PER_PORT;
    localparam int NUM_MUX      = NUM_PORTS * MUX_PER_PORT;
    localparam int NUM_PADS     = NUM_PORTS * PORT_W;

    logic [NUM_MUX-1:0][SEL_W-1:0] sel_w;
    logic [NUM_MUX-1:0] dir_w, inv_w, od_w;
    logic [NUM_MUX-1:0] valid_w, d_w, coe_w, pin_in_w;

    gpx_regs #(.NUM_MUX(NUM_MUX), .NUM_PADS(NUM_PADS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .be(be), .raw_in(pad_in),
        .rdata(rdata), .sel(sel_w), .dir(dir_w), .inv(inv_w), .od(od_w)
    );

    gpx_route #(.NUM_MUX(NUM_MUX), .NUM_CORE(NUM_CORE)) route_i (
        .sel(sel_w), .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in_w),
        .pin_valid(valid_w), .pin_d(d_w), .pin_coe(coe_w), .core_in(core_in)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        localparam int PORT = p / PORT_W;
        localparam int LOC  = p % PORT_W;
        if (LOC < MUX_PER_PORT) begin : g_mux
            localparam int M = PORT * MUX_PER_PORT + LOC;
            assign pin_in_w[M] = pad_in[p];
            gpx_pad pad_i (
                .valid(valid_w[M]), .d(d_w[M]), .coe(coe_w[M]),
                .dir(dir_w[M]), .inv(inv_w[M]), .od(od_w[M]),
                .pout(pad_out[p]), .poe(pad_oe[p])
            );
        end else begin : g_led
            assign pad_out[p] = led_i[PORT * LEDS_PER_PORT + LOC - MUX_PER_PORT];
            assign pad_oe[p]  = 1'b1;
        end
    end
endmodule

// File: rtl/gpio_pin_xbar_chk.sv
module gpio_pin_xbar_chk
    import gpx_pkg::*;
#(
    parameter int NUM_PORTS     = 1,
    parameter int PORT_W        = 37,
    parameter int LEDS_PER_PORT = 2,
    parameter int NUM_CORE      = 35
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    wr_en,
    input logic                                    rd_en,
    input logic [31:0]                             rdata,
    input logic [NUM_CORE-1:0]                     core_out,
    input logic [NUM_CORE-1:0]                     core_oe,
    input logic [NUM_PORTS*LEDS_PER_PORT-1:0]      led_i,
    input logic [NUM_PORTS*PORT_W-1:0]             pad_out,
    input logic [NUM_PORTS*PORT_W-1:0]             pad_oe,
    input logic [NUM_PORTS*(PORT_W-LEDS_PER_PORT)-1:0][SEL_W-1:0] sel,
    input logic [NUM_PORTS*(PORT_W-LEDS_PER_PORT)-1:0]            od
);
    localparam int MUX_PER_PORT = PORT_W - LEDS_PER_PORT;

    for (genvar p = 0; p < NUM_PORTS * PORT_W; p++) begin : g_chk
        localparam int PORT = p / PORT_W;
        localparam int LOC  = p % PORT_W;
        if (LOC < MUX_PER_PORT) begin : g_mux
            localparam int M = PORT * MUX_PER_PORT + LOC;
            a_r5_range_input: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(sel[M]) >= NUM_CORE) |-> (!pad_oe[p] && !pad_out[p]));
            a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
                od[M] |-> !pad_out[p]);
        end else begin : g_led
            a_r10_led_bypass: assert property (@(posedge clk) disable iff (!rst_n)
                pad_oe[p] && (pad_out[p] == led_i[PORT * LEDS_PER_PORT + LOC - MUX_PER_PORT]));
        end
    end

    a_r11_pads_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $stable(core_out) && $stable(core_oe) && $stable(led_i))
        |-> ($stable(pad_out) && $stable(pad_oe)));

    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));
endmodule

bind gpio_pin_xbar gpio_pin_xbar_chk #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
    .LEDS_PER_PORT(LEDS_PER_PORT), .NUM_CORE(NUM_CORE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .core_out(core_out), .core_oe(core_oe), .led_i(led_i),
    .pad_out(pad_out), .pad_oe(pad_oe), .sel(sel_w), .od(od_w)
);

// File: tb/gpio_pin_xbar_tb_top.sv
module gpio_pin_xbar_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2, PW = 37, LP = 2, NC = 40;
    localparam int MPP = PW - LP;
    localparam int NPADS = NP * PW;
    localparam int SELB = 'h1120, DIRB = 'h1100, INVB = 'h1108, ODB = 'h1110, RAWB = 'h1118;

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [3:0]  be = '0;
    logic [NC-1:0] core_out = 40'h9A5C3E1D27, core_oe = '1, core_in;
    logic [NP*LP-1:0] led_i = '0;
    logic [NPADS-1:0] pad_in = '0, pad_out, pad_oe;

    int n_chk = 0, n_fail = 0;

    gpio_pin_xbar #(.NUM_PORTS(NP), .PORT_W(PW), .LEDS_PER_PORT(LP), .NUM_CORE(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .be(be), .rdata(rdata), .core_out(core_out), .core_oe(core_oe),
        .core_in(core_in), .led_i(led_i), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int padof(input int m);
        return (m / MPP) * PW + (m % MPP);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = 16'(a); be = b; wdata = d;
        @(negedge clk);
        wr_en = 0; be = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; addr = 16'(a);
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        int bad = 0;
        chk(rdata == 0, "R1 rdata reset", 64'(rdata), 0);
        rd(SELB, d);      chk(d == 32'h03020100, "R1 selector word 0", 64'(d), 64'h03020100);
        rd(SELB + 17, d); chk(d == 32'h00004544, "R2 partial last word", 64'(d), 64'h00004544);
        rd(DIRB, d);      chk(d == 0, "R1 direction reset", 64'(d), 0);
        for (int m = 0; m < NC; m++)
            if (pad_out[padof(m)] !== core_out[m] || pad_oe[padof(m)] !== 1'b1) bad++;
        chk(bad == 0, "R1 straight mapping", 64'(bad), 0);
        bad = 0;
        for (int m = NC; m < NP * MPP; m++)
            if (pad_oe[padof(m)] !== 1'b0 || pad_out[padof(m)] !== 1'b0) bad++;
        chk(bad == 0, "R5 pins beyond core count", 64'(bad), 0);
    endtask

    task automatic t_remap();
        logic [31:0] d;
        wr(SELB, 4'b0001, 32'hAABBCC05);
        rd(SELB, d); chk(d == 32'h03020105, "R3 single byte write", 64'(d), 64'h03020105);
        chk(pad_out[0] == core_out[5], "R2 pin0 carries core5", 64'(pad_out[0]), 64'(core_out[5]));
        wr(SELB + 1, 4'b0100, 32'h11272233);
        rd(SELB + 1, d); chk(d == 32'h07270504, "R3 byte 2 of word 1", 64'(d), 64'h07270504);
        chk(pad_out[6] == core_out[39], "R2 pin6 carries core39", 64'(pad_out[6]), 64'(core_out[39]));
    endtask

    task automatic t_oor();
        wr(SELB, 4'b0010, 32'h0000FF00);
        wr(SELB, 4'b1000, 32'h28000000);
        wr(DIRB, 4'b0001, 32'h0000000A);
        chk(pad_oe[1] == 0 && pad_out[1] == 0, "R5 selector 0xFF", {pad_oe[1], pad_out[1]}, 0);
        chk(pad_oe[3] == 0 && pad_out[3] == 0, "R5 selector equal NUM_CORE", {pad_oe[3], pad_out[3]}, 0);
    endtask

    task automatic t_dir();
        logic [31:0] d;
        core_oe = '0;
        wr(DIRB, 4'b0001, 32'h00000004);
        rd(DIRB, d); chk(d == 32'h4, "R2 direction readback", 64'(d), 4);
        core_out[2] = 1'b1; #1;
        chk(pad_oe[2] == 1 && pad_out[2] == 1, "R4 dir bit drives 1", {pad_oe[2], pad_out[2]}, 2'b11);
        core_out[2] = 1'b0; #1;
        chk(pad_oe[2] == 1 && pad_out[2] == 0, "R4 dir bit drives 0", {pad_oe[2], pad_out[2]}, 2'b10);
        chk(pad_oe[4] == 0 && pad_out[4] == 0, "R4 disabled pin", {pad_oe[4], pad_out[4]}, 0);
        core_oe[4] = 1'b1; core_out[4] = 1'b1; #1;
        chk(pad_oe[4] == 1 && pad_out[4] == 1, "R4 core enable drives", {pad_oe[4], pad_out[4]}, 2'b11);
    endtask

    task automatic t_inv_od();
        wr(INVB, 4'b0001, 32'h4);
        core_out[2] = 1'b0; #1;
        chk(pad_out[2] == 1, "R6 inverted output", 64'(pad_out[2]), 1);
        wr(ODB, 4'b0001, 32'h4);
        core_out[2] = 1'b1; #1;
        chk(pad_oe[2] == 1 && pad_out[2] == 0, "R7 open drain pulls low", {pad_oe[2], pad_out[2]}, 2'b10);
        core_out[2] = 1'b0; #1;
        chk(pad_oe[2] == 0 && pad_out[2] == 0, "R7 open drain releases", {pad_oe[2], pad_out[2]}, 0);
        wr(INVB, 4'b0001, 32'h0);
        wr(ODB, 4'b0001, 32'h0);
    endtask

    task automatic t_input();
        pad_in = '0; pad_in[5] = 1'b1; #1;
        chk(core_in == 40'h20, "R8 pin5 to core5", 64'(core_in), 64'h20);
        pad_in = '0; pad_in[0] = 1'b1; #1;
        chk(core_in == 40'h20, "R8 remapped pin0 to core5", 64'(core_in), 64'h20);
        pad_in = '0; pad_in[41] = 1'b1; #1;
        chk(core_in == 40'h80_0000_0000, "R8 second port pin to core39", 64'(core_in), 64'h8000000000);
        pad_in = '0; pad_in[38] = 1'b1; #1;
        chk(core_in == 40'h10_0000_0000, "R8 pad38 to core36", 64'(core_in), 64'h1000000000);
        pad_in = '0; pad_in[1] = 1'b1; pad_in[35] = 1'b1; #1;
        chk(core_in == 0, "R8 unselected and LED pads", 64'(core_in), 0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        pad_in = {10'h2AB, 32'hCDEF0123, 32'h456789AB};
        rd(RAWB, d);     chk(d == 32'h456789AB, "R9 raw word 0", 64'(d), 64'h456789AB);
        rd(RAWB + 1, d); chk(d == 32'hCDEF0123, "R9 raw word 1", 64'(d), 64'hCDEF0123);
        rd(RAWB + 2, d); chk(d == 32'h2AB, "R9 raw word 2", 64'(d), 64'h2AB);
    endtask

    task automatic t_led();
        led_i = 4'b1001; #1;
        chk({pad_out[73], pad_out[72], pad_out[36], pad_out[35]} == 4'b1001, "R10 LED data",
            64'({pad_out[73], pad_out[72], pad_out[36], pad_out[35]}), 64'b1001);
        wr(SELB + 8, 4'b1111, 32'hFFFFFFFF);
        chk({pad_oe[73], pad_oe[72], pad_oe[36], pad_oe[35]} == 4'b1111 &&
            {pad_out[73], pad_out[72], pad_out[36], pad_out[35]} == 4'b1001, "R10 LED after selector write",
            64'({pad_oe[73], pad_oe[72], pad_oe[36], pad_oe[35]}), 64'hF);
    endtask

    task automatic t_timing();
        logic [31:0] d;
        core_oe = '1;
        @(negedge clk);
        wr_en = 1; addr = 16'(SELB); be = 4'b0001; wdata = 32'h7;
        #1;
        chk(pad_out[0] == core_out[5], "R11 no effect before edge", 64'(pad_out[0]), 64'(core_out[5]));
        @(negedge clk);
        wr_en = 0; be = '0;
        chk(pad_out[0] == core_out[7], "R11 effect after edge", 64'(pad_out[0]), 64'(core_out[7]));
        @(negedge clk);
        rd_en = 1; addr = 16'(SELB);
        #1;
        d = rdata;
        @(negedge clk);
        rd_en = 0;
        chk(rdata == 32'h2802FF07, "R12 read after edge", 64'(rdata), 64'h2802FF07);
        chk(d == 32'h2AB, "R12 rdata held before edge", 64'(d), 64'h2AB);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_remap();
        t_oor();
        t_dir();
        t_inv_od();
        t_input();
        t_raw();
        t_led();
        t_timing();
        report();
    end
endmodule